// File: doc/BRIEF.md
# Parallel Port Control Register

This block is the register file of a three-port parallel interface. A host reaches it over a byte-wide bus with a two-bit register address and active-low select, read and write strobes. It holds the output latches for an eight-bit port A, an eight-bit port B and an eight-bit port C, and a configuration register that sets the direction of four port groups: port A, port B, the upper nibble of port C and the lower nibble of port C. In basic mode, a port set as output drives its latch onto the pins. A port set as input returns its pin values to the host when the host reads it.

One address carries two kinds of command, told apart by bit 7 of the written byte. A configuration word sets the modes and directions and clears every latch. A bit command sets or clears a single port C bit and leaves the other seven bits as they were, so the host needs no read-modify-write. The handshake modes are stored and brought out on mode outputs, but this block does not act on them. Pad direction is given by separate output-enable signals.

Top module: `ppi_regfile`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block returns to its reset state. In that state every port is an input in mode 0: all output-enables are 0, grp_a_mode is 0 and grp_b_mode is 0. All three output latches are 0 and rdata is 0.
- R2: A write selects its register by address: 0 is port A, 1 is port B, 2 is port C and 3 is control. A write to port A, B or C loads that latch, and pa_out, pb_out or pc_out shows the new value after the clock edge that detects the write.
- R3: A control write with bit 7 set is a configuration word. Its bits 6:5 set grp_a_mode: 00 gives 0, 01 gives 1, and 10 or 11 gives 2. The value 3 never appears on grp_a_mode.
- R4: In a configuration word, bits 4, 1, 3 and 0 set the direction of port A, port B, the upper nibble of port C and the lower nibble of port C, in that order. A bit value of 1 means input, so the matching enable (pa_oe, pb_oe, pc_oe[1], pc_oe[0]) is driven low. A bit value of 0 drives it high. The enables and mode outputs change only on a control write.
- R5: Bit 2 of a configuration word sets grp_b_mode: 0 gives mode 0 and 1 gives mode 1.
- R6: A configuration word clears all three output latches to 0x00.
- R7: A control write with bit 7 clear is a bit command. Bits 3:1 choose the port C bit and bit 0 is its new value. Bits 6:4 are ignored. The other port C bits, ports A and B and the configuration all stay unchanged.
- R8: A read of port A or port B returns the latch if that port is an output, or its pins if it is an input. A read of port C builds each nibble the same way, using that nibble's own direction.
- R9: A read of address 3 returns 0x00.
- R10: Each strobe acts once, on the first clock edge at which it is seen asserted with select. A write held low for several cycles loads only the data present at that first edge. A read held low keeps the value captured at that first edge.
- R11: While cs_n is high, rd_n and wr_n have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Registered read data to host |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 2 | Port C enables: bit 1 upper nibble, bit 0 lower nibble |
| grp_a_mode | output | 2 | Stored group A mode (0, 1, 2) |
| grp_b_mode | output | 1 | Stored group B mode (0, 1) |

## Verification
The configuration register is visible directly on the enables and mode outputs. A wrong decode of the configuration word therefore shows up one cycle after the control write, and the bench checks those outputs right after each control write. A wrong direction bit that the enables do not expose would still appear on the next read of the port concerned, because the read would return the latch instead of the pins, or the pins instead of the latch. A bit command that changes a neighbouring bit shows on pc_out in the cycle after the write. A strobe edge detector that fires more than once shows up as a latch or read value taken from data that arrived later than the first cycle of a held strobe.

// File: rtl/ppi_pkg.sv
// Shared types for the parallel port register file.
// Assumes an eight-bit host bus and eight-bit ports.
package ppi_pkg;
    localparam int PORT_W = 8;
    localparam int NIB_W  = PORT_W / 2;
    localparam int IDX_W  = $clog2(PORT_W);

    typedef enum logic [1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] a_mode;
        logic       a_in;
        logic       cu_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } port_cfg_t;

    localparam port_cfg_t CFG_RESET = '{a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                        b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_strobe_edge.sv
// Detects the cycle in which a selected strobe first shows asserted.
// Assumes the strobe and select inputs are synchronous to clk.
module ppi_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic fire
);
    logic seen_q;

    // Remember the previous sampled strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= active;
    end

    assign fire = active & ~seen_q;
endmodule

// File: rtl/ppi_ctrl_decode.sv
// Splits a control write into a configuration load or a port C bit command,
// and holds the configuration register. Assumes wr_ctrl lasts one cycle.
module ppi_ctrl_decode
    import ppi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [7:0]       wdata,
    output port_cfg_t        cfg,
    output logic             cfg_load,
    output logic             bit_load,
    output logic [IDX_W-1:0] bit_idx,
    output logic             bit_val
);
    port_cfg_t cfg_q;
    port_cfg_t cfg_next;

    assign cfg_load = wr_ctrl &  wdata[7];
    assign bit_load = wr_ctrl & ~wdata[7];
    assign bit_idx  = wdata[IDX_W:1];
    assign bit_val  = wdata[0];

    // Map configuration word fields onto the stored settings.
    always_comb begin
        cfg_next.a_mode = {wdata[6], wdata[5] & ~wdata[6]};
        cfg_next.a_in   = wdata[4];
        cfg_next.cu_in  = wdata[3];
        cfg_next.b_mode = wdata[2];
        cfg_next.b_in   = wdata[1];
        cfg_next.cl_in  = wdata[0];
    end

    // Hold the configuration between configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= CFG_RESET;
        else if (cfg_load) cfg_q <= cfg_next;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/ppi_out_latch.sv
// Output latch of one port: whole-word load, single-bit update, clear.
// Clear wins over load, and load wins over the bit update.
module ppi_out_latch #(
    parameter int W     = 8,
    parameter bit HAS_BIT = 1'b0,
    localparam int IW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld,
    input  logic [W-1:0]  ld_data,
    input  logic          bit_ld,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    output logic [W-1:0]  q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        if (HAS_BIT) begin : g_cmd
            assign hit = bit_ld && (bit_idx == IW'(i));
        end else begin : g_nocmd
            assign hit = 1'b0;
        end

        // Update one latch bit from the highest-priority source.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) q[i] <= 1'b0;
            else if (ld)       q[i] <= ld_data[i];
            else if (hit)      q[i] <= bit_val;
        end
    end
endmodule

// File: rtl/ppi_regfile.sv
// Host-side register file of a three-port parallel interface (basic mode).
// Assumes bus strobes are synchronous to clk; acts once per strobe edge.
module ppi_regfile
    import ppi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic              pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [1:0]        pc_oe,
    output logic [1:0]        grp_a_mode,
    output logic              grp_b_mode
);
    logic             wr_fire, rd_fire;
    logic             cfg_load, bit_load, bit_val;
    logic [IDX_W-1:0] bit_idx;
    port_cfg_t        cfg;
    reg_sel_e         sel;
    logic [7:0]       rd_mux;
    logic [7:0]       rdata_q;

    assign sel = reg_sel_e'(addr);

    ppi_strobe_edge u_wr_edge (
        .clk(clk), .rst_n(rst_n), .active(~cs_n & ~wr_n), .fire(wr_fire));
    ppi_strobe_edge u_rd_edge (
        .clk(clk), .rst_n(rst_n), .active(~cs_n & ~rd_n), .fire(rd_fire));

    ppi_ctrl_decode u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_fire && sel == SEL_CTRL), .wdata(wdata),
        .cfg(cfg), .cfg_load(cfg_load), .bit_load(bit_load),
        .bit_idx(bit_idx), .bit_val(bit_val));

    ppi_out_latch #(.W(PORT_W), .HAS_BIT(1'b0)) u_pa (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load),
        .ld(wr_fire && sel == SEL_PA), .ld_data(wdata),
        .bit_ld(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out));

    ppi_out_latch #(.W(PORT_W), .HAS_BIT(1'b0)) u_pb (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load),
        .ld(wr_fire && sel == SEL_PB), .ld_data(wdata),
        .bit_ld(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out));

    ppi_out_latch #(.W(PORT_W), .HAS_BIT(1'b1)) u_pc (
        .clk(clk), .rst_n(rst_n), .clr(cfg_load),
        .ld(wr_fire && sel == SEL_PC), .ld_data(wdata),
        .bit_ld(bit_load), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_out));

    // Choose latch or pins per port group for the host read path.
    always_comb begin
        unique case (sel)
            SEL_PA:   rd_mux = cfg.a_in ? pa_in : pa_out;
            SEL_PB:   rd_mux = cfg.b_in ? pb_in : pb_out;
            SEL_PC:   rd_mux = {cfg.cu_in ? pc_in[PORT_W-1:NIB_W] : pc_out[PORT_W-1:NIB_W],
                                cfg.cl_in ? pc_in[NIB_W-1:0]      : pc_out[NIB_W-1:0]};
            default:  rd_mux = 8'h00;
        endcase
    end

    // Capture read data once per read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= 8'h00;
        else if (rd_fire) rdata_q <= rd_mux;
    end

    assign rdata      = rdata_q;
    assign pa_oe      = ~cfg.a_in;
    assign pb_oe      = ~cfg.b_in;
    assign pc_oe      = {~cfg.cu_in, ~cfg.cl_in};
    assign grp_a_mode = cfg.a_mode;
    assign grp_b_mode = cfg.b_mode;
endmodule

// File: rtl/ppi_regfile_chk.sv
// Port-level property checker for ppi_regfile, attached by bind.
// Keeps its own strobe history; looks only at the top-level ports.
module ppi_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_out,
    input logic       pa_oe,
    input logic [7:0] pb_out,
    input logic       pb_oe,
    input logic [7:0] pc_out,
    input logic [1:0] pc_oe,
    input logic [1:0] grp_a_mode,
    input logic       grp_b_mode
);
    logic wr_prev, rd_prev;
    logic wr_edge, rd_edge;

    // Track the previous strobe levels seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_prev <= 1'b0;
            rd_prev <= 1'b0;
        end else begin
            wr_prev <= !cs_n && !wr_n;
            rd_prev <= !cs_n && !rd_n;
        end
    end

    assign wr_edge = !cs_n && !wr_n && !wr_prev;
    assign rd_edge = !cs_n && !rd_n && !rd_prev;

    a_r3_mode_code: assert property (@(posedge clk) disable iff (!rst_n)
        grp_a_mode != 2'b11);

    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wr_n || addr != 2'd3) |=>
            $stable({pa_oe, pb_oe, pc_oe, grp_a_mode, grp_b_mode}));

    a_r6_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_edge && addr == 2'd3 && wdata[7]) |=>
            (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_edge && addr == 2'd3 && !wdata[7]) |=>
            ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out)));

    a_r9_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_edge && addr == 2'd3) |=> rdata == 8'h00);

    a_r11_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(rdata) && $stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
endmodule

bind ppi_regfile ppi_regfile_chk u_chk (.*);

// File: tb/ppi_regfile_bench.sv
// Scoreboard bench: driver tasks queue expectations, a monitor compares them.
module ppi_regfile_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pb_out, pc_out;
    logic       pa_oe, pb_oe;
    logic [1:0] pc_oe, grp_a_mode;
    logic       grp_b_mode;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    always #5 clk = ~clk;

    ppi_regfile u_ppi_regfile (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode));

    // Observation points: 0 rdata, 1 pa_out, 2 pb_out, 3 pc_out,
    // 4 {pa_oe,pb_oe,pc_oe}, 5 {grp_a_mode,grp_b_mode}
    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return rdata;
            1: return pa_out;
            2: return pb_out;
            3: return pc_out;
            4: return {4'h0, pa_oe, pb_oe, pc_oe};
            default: return {5'h0, grp_a_mode, grp_b_mode};
        endcase
    endfunction

    // Monitor: pop and compare every queued expectation at a sample point.
    always begin
        @(sample_ev);
        while (exp_q.size() > 0) begin
            exp_t item;
            logic [7:0] got;
            item = exp_q.pop_front();
            got = observe(item.sel);
            checks++;
            if (got !== item.val) begin
                errors++;
                $display("FAIL %s: point %0d got %02h expected %02h", item.tag, item.sel, got, item.val);
            end
        end
    end

    task automatic expect_val(int sel, logic [7:0] val, string tag);
        exp_t item;
        item.sel = sel; item.val = val; item.tag = tag;
        exp_q.push_back(item);
    endtask

    task automatic sample();
        ->sample_ev;
        #1;
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(logic [1:0] a);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_val(0, 8'h00, "R1 rdata");
        expect_val(1, 8'h00, "R1 pa_out");
        expect_val(3, 8'h00, "R1 pc_out");
        expect_val(4, 8'h00, "R1 enables");
        expect_val(5, 8'h00, "R1 modes");
        sample();
        rst_n = 1'b1;

        // R8: port A is an input after reset, so the pins are read
        pa_in = 8'h5A;
        bus_read(2'd0);
        expect_val(0, 8'h5A, "R8 input read A");
        sample();

        // R4: all outputs, mode 0
        bus_write(2'd3, 8'h80);
        expect_val(4, 8'h0F, "R4 all outputs");
        expect_val(5, 8'h00, "R3 mode 0");
        sample();

        // R2: latch writes by address
        bus_write(2'd0, 8'h3C);
        bus_write(2'd1, 8'hC3);
        bus_write(2'd2, 8'hA5);
        expect_val(1, 8'h3C, "R2 port A");
        expect_val(2, 8'hC3, "R2 port B");
        expect_val(3, 8'hA5, "R2 port C");
        sample();

        // R8: output port reads its latch, not the pins
        bus_read(2'd0);
        expect_val(0, 8'h3C, "R8 output read A");
        sample();

        // R7: set bit 3 with ignored bits 6:4 high, then clear bit 5
        bus_write(2'd3, 8'h77);
        expect_val(3, 8'hAD, "R7 set bit3");
        expect_val(4, 8'h0F, "R7 enables kept");
        expect_val(1, 8'h3C, "R7 port A kept");
        sample();
        bus_write(2'd3, 8'h0A);
        expect_val(3, 8'h8D, "R7 clear bit5");
        expect_val(5, 8'h00, "R7 modes kept");
        sample();

        // R3 R5 R6: mode 2 / mode 1 word with mixed directions
        bus_write(2'd3, 8'hE5);
        expect_val(5, 8'h05, "R3 R5 mode2 and B mode1");
        expect_val(4, 8'h0E, "R4 lower nibble input");
        expect_val(1, 8'h00, "R6 clear A");
        expect_val(2, 8'h00, "R6 clear B");
        expect_val(3, 8'h00, "R6 clear C");
        sample();
        bus_write(2'd3, 8'hA0);
        expect_val(5, 8'h02, "R3 mode 1");
        sample();
        bus_write(2'd3, 8'hC0);
        expect_val(5, 8'h04, "R3 mode 2 from 10");
        sample();

        // R8: port C upper input, lower output
        bus_write(2'd3, 8'h88);
        expect_val(4, 8'h0D, "R4 upper nibble input");
        sample();
        bus_write(2'd2, 8'h5A);
        pc_in = 8'hC3;
        bus_read(2'd2);
        expect_val(0, 8'hCA, "R8 mixed nibble read");
        sample();

        // R9: control register reads as zero
        bus_read(2'd3);
        expect_val(0, 8'h00, "R9 control read");
        sample();

        // R10: held write loads only the first data
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; wdata = 8'h11;
        @(negedge clk); wdata = 8'h22;
        @(negedge clk); wdata = 8'h33;
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        expect_val(1, 8'h11, "R10 held write");
        sample();

        // R10: held read keeps the first captured value
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'd2; pc_in = 8'h70;
        @(negedge clk); pc_in = 8'hF0;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        expect_val(0, 8'h7A, "R10 held read");
        sample();

        // R11: strobes without select do nothing
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; wdata = 8'h77;
        @(negedge clk); wr_n = 1'b1; rd_n = 1'b0; addr = 2'd3;
        @(negedge clk); rd_n = 1'b1;
        expect_val(1, 8'h11, "R11 no write");
        expect_val(0, 8'h7A, "R11 no read");
        sample();
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd3; wdata = 8'h80;
        @(negedge clk); wr_n = 1'b1;
        expect_val(4, 8'h0D, "R11 config kept");
        sample();

        // R1: reset in mid-run returns everything to the start state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        expect_val(1, 8'h00, "R1 reset clears A");
        expect_val(4, 8'h00, "R1 reset inputs");
        sample();
        rst_n = 1'b1;

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule